// File: doc/BRIEF.md
# Segmented Rational Transfer-Function Filter

This block streams 8-bit fractional samples through a programmable rational filter: every output is the input shaped by a numerator polynomial and divided by a denominator polynomial in the delay operator. Setting every denominator tap to zero turns it into a pure FIR. Before a vector is processed, software writes the numerator and denominator taps through a small write port. Samples then enter and leave on valid/ready streams, at up to one sample per clock.

The taps are not kept in one long line. They are split into equal segments. Each segment owns the numerator taps, the denominator taps and the state registers for a contiguous range of delay indices. Each segment exchanges a single partial sum with the segment directly below it. Segments can be added to reach a higher order without touching the others. A head stage owns the zero-delay numerator tap, the rounding and saturation step, and the output register. A synchronous clear empties all filter state between vectors.

Top module: `tf_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and all taps and state are zero.
- R2: With every denominator tap zero, each output equals the rounded, saturated value of the sum over k of b[k]·x[n−k], for k from 0 to ORDER.
- R3: With nonzero denominator taps, each output equals the rounded, saturated value of Σ b[k]·x[n−k] − Σ a[k]·y[n−k], with k from 1 to ORDER in the second sum. The past outputs y are the saturated 8-bit values. The sums are exact at full precision.
- R4: Samples and taps are 8-bit two's complement codes, each worth code/128. The full-precision sum has 14 fractional bits. It is reduced to 7 fractional bits by adding 64 and then shifting right arithmetically by 7, which rounds halves upward.
- R5: A rounded result above 127 is output as 127, and one below −128 is output as −128.
- R6: A sample accepted on one edge produces `out_valid` high after that edge. Back-to-back samples are accepted on consecutive cycles while `out_ready` is high.
- R7: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_data` and `out_valid` hold.
- R8: A cycle with `clr` high zeroes every state register and drops `out_valid`. Taps are kept. The next sample is filtered as if all past inputs and outputs were zero.
- R9: `cfg_bank` 0 selects numerator tap `cfg_idx` (0..ORDER). `cfg_bank` 1 selects denominator tap `cfg_idx` (1..ORDER). A write to denominator index 0 is ignored, because that tap is fixed at 1.0.
- R10: Tap writes are ignored from the first accepted sample until the next clear. Writes after a clear take effect.
- R11: The impulse response shows b[k] at delay k for every k, including the indices on both sides of a segment boundary. ORDER must be a multiple of the segment size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of filter state and run |
| cfg_we | input | 1 | Tap write strobe |
| cfg_bank | input | 1 | 0 numerator, 1 denominator |
| cfg_idx | input | IDX_W | Tap delay index |
| cfg_data | input | COEF_W | Tap value, signed fraction |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Input sample, signed fraction |
| in_ready | output | 1 | Input sample can be taken |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DATA_W | Output sample, signed fraction |
| out_ready | input | 1 | Consumer takes output |

## Verification
The hardest case to reach is a clear that arrives while a result is held by back-pressure. The stimulus stalls the consumer, lets one sample enter, and pulses the clear while the output is frozen. It then checks that the held result is gone and that the following samples see zero history. A second hard case is a feedback tap in the upper segment. The IIR vector drives a denominator tap beyond the first segment while the consumer stalls on a fixed cycle pattern. The comparison then covers feedback from both segments, and the hold behaviour, in one run.

// File: rtl/tf_pkg.sv
// Shared types for the segmented transfer-function filter.
package tf_pkg;
    // Tap bank selector carried on the write port.
    typedef enum logic {
        BANK_NUM = 1'b0,
        BANK_DEN = 1'b1
    } bank_e;
endpackage

// File: rtl/tf_segment.sv
// One slice of the transposed direct-form-II tap line.
// Holds numerator and denominator taps plus state for delay indices
// BASE .. BASE+TAPS-1. Takes the partial sum of the segment above and
// hands its lowest state to the segment below.
// Assumes: x and y are valid whenever step is high.
module tf_segment
    import tf_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CW   = 8,
    parameter int SW   = 21,
    parameter int IW   = 4,
    parameter int TAPS = 4,
    parameter int BASE = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic                 run_busy,
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    input  logic signed [SW-1:0] upper,
    output logic signed [SW-1:0] lower,
    input  logic                 cfg_we,
    input  logic                 cfg_bank,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [CW-1:0]        cfg_data
);
    logic signed [CW-1:0] b_q [TAPS];
    logic signed [CW-1:0] a_q [TAPS];
    logic signed [SW-1:0] s_q [TAPS];
    logic signed [SW-1:0] s_nx [TAPS];
    logic                 wr_ok;

    assign wr_ok = cfg_we && !run_busy;
    assign lower = s_q[0];

    // Next state of each delay: own products plus the state one index higher.
    always_comb begin
        for (int t = 0; t < TAPS; t++) begin
            s_nx[t] = SW'(b_q[t] * x) - SW'(a_q[t] * y)
                    + ((t == TAPS - 1) ? upper : s_q[(t + 1) % TAPS]);
        end
    end

    // Tap storage: written only between runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < TAPS; t++) begin
                b_q[t] <= '0;
                a_q[t] <= '0;
            end
        end else if (wr_ok) begin
            for (int t = 0; t < TAPS; t++) begin
                if (cfg_idx == IW'(BASE + t)) begin
                    if (bank_e'(cfg_bank) == BANK_NUM) b_q[t] <= cfg_data;
                    else                               a_q[t] <= cfg_data;
                end
            end
        end
    end

    // State registers: cleared on reset or clr, advanced per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int t = 0; t < TAPS; t++) s_q[t] <= '0;
        end else if (step) begin
            for (int t = 0; t < TAPS; t++) s_q[t] <= s_nx[t];
        end
    end

    assert_clear_zeroes_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lower == '0));

    for (genvar g = 0; g < TAPS; g++) begin : g_frz
        assert_taps_frozen_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
            run_busy |=> ($stable(b_q[g]) && $stable(a_q[g])));
    end
endmodule

// File: rtl/tf_head.sv
// Output stage of the filter: zero-delay numerator tap, rounding,
// saturation, output register and stream handshake. Also tracks whether
// a run is in progress, which locks the tap write port.
// Assumes: s_first is the lowest state of the segment chain.
module tf_head
    import tf_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 8,
    parameter int SW = 21,
    parameter int IW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    input  logic                 out_ready,
    input  logic                 cfg_we,
    input  logic                 cfg_bank,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [CW-1:0]        cfg_data,
    input  logic signed [SW-1:0] s_first,
    output logic signed [DW-1:0] y_fb,
    output logic                 step,
    output logic                 busy
);
    localparam logic signed [SW-1:0] RND  = SW'(1) <<< (CW - 2);
    localparam logic signed [SW-1:0] Y_HI = SW'(2 ** (DW - 1) - 1);
    localparam logic signed [SW-1:0] Y_LO = -Y_HI - SW'(1);

    logic signed [CW-1:0] b0_q;
    logic signed [SW-1:0] y_full;
    logic signed [SW-1:0] y_rnd;

    assign in_ready = (!out_valid || out_ready) && !clr;
    assign step     = in_valid && in_ready;

    // Full-precision sum, round half up, clamp to the sample range.
    always_comb begin
        y_full = SW'(b0_q * in_data) + s_first;
        y_rnd  = (y_full + RND) >>> (CW - 1);
        if (y_rnd > Y_HI)      y_fb = Y_HI[DW-1:0];
        else if (y_rnd < Y_LO) y_fb = Y_LO[DW-1:0];
        else                   y_fb = y_rnd[DW-1:0];
    end

    // Zero-delay numerator tap: written only between runs.
    always_ff @(posedge clk) begin
        if (!rst_n) b0_q <= '0;
        else if (cfg_we && !busy && bank_e'(cfg_bank) == BANK_NUM && cfg_idx == '0)
            b0_q <= cfg_data;
    end

    // Run flag: set by the first accepted sample, dropped by clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) busy <= 1'b0;
        else if (step)     busy <= 1'b1;
    end

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (clr) begin
            out_valid <= 1'b0;
        end else if (step) begin
            out_valid <= 1'b1;
            out_data  <= y_fb;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));
    assert_no_accept_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    assert_clear_drops_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_valid);
    assert_result_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> out_valid);
endmodule

// File: rtl/tf_filter.sv
// Top of the segmented rational filter: a head stage plus a chain of
// identical tap segments linked only to their neighbours.
// Assumes: ORDER is a multiple of SEG_TAPS.
module tf_filter #(
    parameter int DATA_W   = 8,
    parameter int COEF_W   = 8,
    parameter int ORDER    = 8,
    parameter int SEG_TAPS = 4,
    parameter int IDX_W    = $clog2(ORDER + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     cfg_we,
    input  logic                     cfg_bank,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [COEF_W-1:0]        cfg_data,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data,
    input  logic                     out_ready
);
    localparam int NSEG = ORDER / SEG_TAPS;
    localparam int SW   = DATA_W + COEF_W + $clog2(2 * ORDER + 2);

    logic signed [SW-1:0]     link [NSEG + 1];
    logic signed [DATA_W-1:0] y_fb;
    logic                     step;
    logic                     busy;

    assign link[NSEG] = '0;

    tf_head #(.DW(DATA_W), .CW(COEF_W), .SW(SW), .IW(IDX_W)) u_head (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .s_first(link[0]), .y_fb(y_fb), .step(step), .busy(busy)
    );

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        tf_segment #(
            .DW(DATA_W), .CW(COEF_W), .SW(SW), .IW(IDX_W),
            .TAPS(SEG_TAPS), .BASE(1 + s * SEG_TAPS)
        ) u_seg (
            .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .run_busy(busy),
            .x(in_data), .y(y_fb), .upper(link[s + 1]), .lower(link[s]),
            .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx), .cfg_data(cfg_data)
        );
    end
endmodule

// File: tb/test_tf_filter.sv
// Scoreboard bench: the driver pushes model results, the monitor compares.
module test_tf_filter;
    localparam int ORD = 8;
    localparam int IW  = $clog2(ORD + 1);

    logic clk = 0, rst_n = 0, clr = 0;
    logic cfg_we = 0, cfg_bank = 0;
    logic [IW-1:0] cfg_idx = '0;
    logic [7:0] cfg_data = '0;
    logic in_valid = 0;
    logic signed [7:0] in_data = '0;
    logic in_ready, out_valid, out_ready;
    logic signed [7:0] out_data;

    tf_filter #(.ORDER(ORD), .SEG_TAPS(4)) i_tf_filter (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always #5 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    int bm [0:ORD], am [0:ORD], xh [0:ORD], yh [0:ORD];
    bit running = 0;
    int exp_q [$];
    string tag_q [$];
    bit bp_mode = 0, stall_all = 0;
    int cyc = 0;
    bit held = 0;
    logic signed [7:0] hdata;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int model_step(input int x);
        int acc, r;
        for (int k = ORD; k > 0; k--) begin
            xh[k] = xh[k-1];
            yh[k] = yh[k-1];
        end
        xh[0] = x;
        acc = 0;
        for (int k = 0; k <= ORD; k++) acc += bm[k] * xh[k];
        for (int k = 1; k <= ORD; k++) acc -= am[k] * yh[k];
        r = (acc + 64) >>> 7;
        if (r > 127) r = 127;
        if (r < -128) r = -128;
        yh[0] = r;
        return r;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k <= ORD; k++) begin
            xh[k] = 0;
            yh[k] = 0;
        end
        running = 0;
    endfunction

    // Consumer ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready = !(stall_all || (bp_mode && (cyc % 3 == 1)));
    end

    // Monitor: pops and compares each transferred result; checks stall hold.
    always @(negedge clk) begin
        if (rst_n && !clr) begin
            if (held) begin
                check(out_valid && out_data == hdata, "R7 hold", int'(out_data), int'(hdata));
                held = 0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) check(0, "unexpected output", int'(out_data), 0);
                else begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_data) == e, t, int'(out_data), e);
                end
            end else if (out_valid) begin
                check(!in_ready, "R7 in_ready", int'(in_ready), 0);
                held = 1;
                hdata = out_data;
            end
        end else held = 0;
    end

    task automatic send(input int x, input string tag);
        in_valid = 1;
        in_data  = x[7:0];
        do @(negedge clk); while (!in_ready);
        exp_q.push_back(model_step(x));
        tag_q.push_back(tag);
        running = 1;
        @(posedge clk);
        #1 in_valid = 0;
    endtask

    task automatic wr(input int bank, input int idx, input int val);
        cfg_we = 1; cfg_bank = bank[0]; cfg_idx = idx[IW-1:0]; cfg_data = val[7:0];
        @(posedge clk);
        #1 cfg_we = 0;
        if (!running && !(bank == 1 && idx == 0)) begin
            if (bank == 0) bm[idx] = val;
            else           am[idx] = val;
        end
    endtask

    task automatic load(input int bv [9], input int av [9]);
        for (int k = 0; k <= ORD; k++) wr(0, k, bv[k]);
        for (int k = 1; k <= ORD; k++) wr(1, k, av[k]);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_clear();
        clr = 1;
        @(posedge clk);
        #1 clr = 0;
        model_clear();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        time t0;
        for (int k = 0; k <= ORD; k++) begin bm[k] = 0; am[k] = 0; end
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(!out_valid, "R1 out_valid", int'(out_valid), 0);
        check(in_ready, "R1 in_ready", int'(in_ready), 1);
        @(posedge clk); #1;

        // R1: zero taps give zero output.
        send(100, "R1 zero taps");
        drain();
        pulse_clear();

        // R2/R9: FIR; the write to the fixed denominator tap must not matter.
        load('{20, -30, 40, 10, 0, -50, 25, 5, 60}, '{0, 0, 0, 0, 0, 0, 0, 0, 0});
        wr(1, 0, 100);
        for (int i = 0; i < 20; i++) send(((i * 37) % 256) - 128, "R2/R9 fir");
        drain();

        // R6: one sample per cycle, result valid after the accepting edge.
        t0 = $time;
        for (int i = 0; i < 8; i++) send(i * 11 - 40, "R6 stream");
        check(($time - t0) == 80, "R6 throughput", int'($time - t0), 80);
        @(negedge clk);
        check(out_valid, "R6 latency", int'(out_valid), 1);
        drain();
        pulse_clear();

        // R11: impulse response over both segments.
        load('{10, 20, 30, 40, 50, 60, 70, 80, 90}, '{0, 0, 0, 0, 0, 0, 0, 0, 0});
        send(127, "R11 impulse");
        for (int i = 0; i < 10; i++) send(0, "R11 impulse tail");
        drain();
        pulse_clear();

        // R4: rounding of half values.
        load('{64, 0, 0, 0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0, 0, 0, 0});
        send(1, "R4 round");
        send(-1, "R4 round");
        send(3, "R4 round");
        send(-3, "R4 round");
        send(127, "R4 round");
        send(-128, "R4 round");
        drain();
        pulse_clear();

        // R5: saturation at both ends.
        load('{127, 127, 0, 0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0, 0, 0, 0});
        send(127, "R5 sat");
        send(127, "R5 sat hi");
        send(-128, "R5 sat");
        send(-128, "R5 sat lo");
        send(0, "R5 sat");
        drain();
        pulse_clear();

        // R3: stable IIR with a feedback tap in the upper segment, back-pressured.
        load('{64, 32, 0, 0, 0, 0, 0, 0, 0}, '{0, -77, 20, 0, 0, 16, 0, 0, 0});
        bp_mode = 1;
        for (int i = 0; i < 30; i++) send((i % 7) * 30 - 90, "R3 iir");

        // R10: writes during a run are ignored.
        wr(0, 0, 0);
        wr(1, 1, 0);
        for (int i = 0; i < 10; i++) send(50 - i * 9, "R10 locked");
        drain();
        bp_mode = 0;

        // R8: clear while a result is held by back-pressure.
        stall_all = 1;
        @(posedge clk); #1;
        send(77, "R8 dropped");
        @(negedge clk);
        exp_q.delete();
        tag_q.delete();
        @(posedge clk); #1;
        pulse_clear();
        @(negedge clk);
        check(!out_valid, "R8 out_valid", int'(out_valid), 0);
        stall_all = 0;
        @(posedge clk); #1;
        for (int i = 0; i < 10; i++) send(i * 20 - 60, "R8 fresh state");
        drain();
        pulse_clear();

        // R10: writes after a clear take effect.
        wr(0, 0, 100);
        wr(1, 5, -40);
        for (int i = 0; i < 10; i++) send(90 - i * 17, "R10 after clear");
        drain();

        finish_run();
    end
endmodule